// File: doc/BRIEF.md
# Two-Key Register Unlock Controller

This block guards the register file of a timekeeping peripheral. After power-on the peripheral is held in reset. It leaves reset only when software writes a fixed 32-bit wake key to the wake register. That wake is permanent. Register access then needs a second, renewable 16-bit password. A correct password opens a time-limited access window. A wrong password closes the window at once. While the window is closed, writes to the protected registers are dropped and reads of them return zero.

The controller decodes a simple register bus. Writes and reads are single-cycle strobes with a byte address. From that bus it drives three things: a peripheral-active level, an access-enabled flag, and one write strobe per protected register. Read data from the protected register file comes in on `reg_rdata`. The controller passes it through only while the window is open. The wake register and the password register can be reached at all times.

Top module: `regfile_unlock`

## Requirements
- R1: After reset, `periph_active` and `access_en` are 0, every bit of `reg_wr_stb` is 0, and `rdata` is 0 while `rd_en` is low.
- R2: A write of 32'hA5EB1357 to byte address 0x00 sets `periph_active` on the next clock edge.
- R3: A write of any other value to address 0x00 leaves `periph_active` unchanged.
- R4: Once `periph_active` is 1, it stays 1 until reset, whatever is written to address 0x00.
- R5: A read of address 0x00 returns `periph_active` in bit 0, with all other bits 0.
- R6: While `periph_active` is 1, a write to address 0x04 whose bits 15:0 equal 16'hA965 sets `access_en` on the next edge. Bits 31:16 of that write are ignored. While `periph_active` is 0, writes to 0x04 have no effect.
- R7: A read of address 0x04 returns `access_en` in bit 16, with all other bits 0.
- R8: A write to address 0x04 whose bits 15:0 differ from 16'hA965 clears `access_en` on the next edge.
- R9: `access_en` stays high for exactly WINDOW clock edges after the edge that set it, then clears by itself. A fresh correct password restarts the full window.
- R10: Protected register i sits at byte address 0x08 + 4*i, for i from 0 to NUM_REGS-1. `reg_wr_stb[i]` is high in the same cycle as a write to that address only while both `periph_active` and `access_en` are 1. At most one strobe is high, and unaligned or out-of-range addresses raise none.
- R11: A read of a protected address returns `reg_rdata` while `access_en` is 1, and returns 0 otherwise. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write request |
| rd_en | input | 1 | Read request; `rdata` is valid in the same cycle |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| reg_rdata | input | 32 | Data of the addressed protected register, from the register file |
| rdata | output | 32 | Read data |
| periph_active | output | 1 | Peripheral released from reset (permanent once set) |
| access_en | output | 1 | Access window open |
| reg_wr_stb | output | NUM_REGS | Per-register write strobes for the protected registers |

## Verification
The assertions assume that `wr_en` and `rd_en` are clean single-cycle levels. They also assume that `addr` and `wdata` are stable around each clock edge, and that `reg_rdata` is whatever the register file presents. The bench drives every bus input on the falling edge and holds it through the next rising edge. Only the rising edge commits state, so no check depends on the order in which processes run at an edge.

The window checks count edges from the password write. The assertion on window expiry uses the internal countdown rather than a deep `$past`.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam logic [31:0] WAKE_KEY  = 32'hA5EB1357;
  localparam logic [15:0] PASS_KEY  = 16'hA965;
  localparam int unsigned WAKE_OFS  = 0;
  localparam int unsigned GATE_OFS  = 4;
  localparam int unsigned PROT_BASE = 8;
  localparam int unsigned FLAG_BIT  = 16;

  // true when a byte address hits one of n protected word registers
  function automatic logic is_prot(input logic [31:0] a, input int unsigned n);
    return (a >= PROT_BASE) && (a < PROT_BASE + 4 * n) && (a[1:0] == 2'b00);
  endfunction

  // word index of a protected register from its byte address
  function automatic int unsigned prot_idx(input logic [31:0] a);
    return (a - PROT_BASE) >> 2;
  endfunction
endpackage

// File: rtl/unlock_wake.sv
module unlock_wake
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              active_o
);
  logic wake_wr, key_hit;
  assign wake_wr = wr_en && (addr == ADDR_W'(WAKE_OFS));
  assign key_hit = wake_wr && (wdata == WAKE_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_o <= 1'b0;
    else if (key_hit) active_o <= 1'b1;
  end

  // R2
  key_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> active_o);
  // R3
  no_false_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !key_hit) |=> !active_o);
  // R4
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> active_o);
endmodule

// File: rtl/unlock_gate.sv
module unlock_gate
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       pwd,
  output logic              open_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic pwd_wr, pwd_ok, pwd_bad, expire;
  assign pwd_wr  = wr_en && active_i && (addr == ADDR_W'(GATE_OFS));
  assign pwd_ok  = pwd_wr && (pwd == PASS_KEY);
  assign pwd_bad = pwd_wr && (pwd != PASS_KEY);
  assign expire  = open_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (pwd_ok) begin
      open_o <= 1'b1;
      cnt_q  <= CNT_W'(WINDOW - 1);
    end else if (pwd_bad || expire) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (open_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R6
  pwd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwd_ok |=> open_o);
  // R8
  bad_pwd_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwd_bad |=> !open_o);
  // R9
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && cnt_q != '0 && !pwd_wr) |=> open_o);
  // R9
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_o) |-> ($past(expire) || $past(pwd_bad)));
  // R6
  open_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |-> active_i);
endmodule

// File: rtl/unlock_decode.sv
module unlock_decode
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                active_i,
  input  logic                open_i,
  input  logic [31:0]         reg_rdata,
  output logic [31:0]         rdata,
  output logic [NUM_REGS-1:0] stb_o
);
  logic granted, prot_hit;
  assign granted  = active_i && open_i;
  assign prot_hit = is_prot(32'(addr), NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
    assign stb_o[i] = wr_en && granted && (addr == ADDR_W'(PROT_BASE + 4 * i));
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(WAKE_OFS))      rdata[0]        = active_i;
      else if (addr == ADDR_W'(GATE_OFS)) rdata[FLAG_BIT] = open_i;
      else if (prot_hit && granted)       rdata           = reg_rdata;
    end
  end

  // R10
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o));
  // R10
  stb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o != '0) |-> (active_i && open_i && wr_en));
  // R11
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && prot_hit && !open_i) |-> (rdata == '0));
endmodule

// File: rtl/regfile_unlock.sv
module regfile_unlock
  import unlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 20,
  parameter int WINDOW   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic [31:0]         reg_rdata,
  output logic [31:0]         rdata,
  output logic                periph_active,
  output logic                access_en,
  output logic [NUM_REGS-1:0] reg_wr_stb
);
  unlock_wake #(.ADDR_W(ADDR_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .active_o(periph_active));

  unlock_gate #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_gate (
    .clk(clk), .rst_n(rst_n), .active_i(periph_active), .wr_en(wr_en),
    .addr(addr), .pwd(wdata[15:0]), .open_o(access_en));

  unlock_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .active_i(periph_active), .open_i(access_en), .reg_rdata(reg_rdata),
    .rdata(rdata), .stb_o(reg_wr_stb));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (reg_wr_stb == '0));
endmodule

// File: tb/test_regfile_unlock.sv
module test_regfile_unlock;
  localparam int AW = 8;
  localparam int NR = 20;
  localparam int WIN = 64;
  localparam logic [31:0] RDV = 32'h5A5A_1234;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic periph_active, access_en;
  logic [NR-1:0] reg_wr_stb;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regfile_unlock #(.ADDR_W(AW), .NUM_REGS(NR), .WINDOW(WIN)) i_regfile_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .reg_rdata(RDV), .rdata(rdata),
    .periph_active(periph_active), .access_en(access_en), .reg_wr_stb(reg_wr_stb));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  // strobe seen in the same cycle as the write request
  task automatic stb_probe(input logic [AW-1:0] a, output logic [31:0] s);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = 32'h1;
    #1 s = 32'(reg_wr_stb);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 active", 32'(periph_active), 0);
    chk("R1 access", 32'(access_en), 0);
    chk("R1 strobes", 32'(reg_wr_stb), 0);
    chk("R1 idle rdata", rdata, 0);
    bus_rd(8'h00, d); chk("R5 read asleep", d, 0);
  endtask

  task automatic t_asleep();
    logic [31:0] s, d;
    bus_wr(8'h00, 32'hA5EB1356); chk("R3 near key", 32'(periph_active), 0);
    bus_wr(8'h04, 32'h0000A965); chk("R6 pwd asleep", 32'(access_en), 0);
    bus_rd(8'h04, d);            chk("R7 flag asleep", d, 0);
    stb_probe(8'h08, s);         chk("R10 strobe asleep", s, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    bus_wr(8'h00, 32'hA5EB1357); chk("R2 wake", 32'(periph_active), 1);
    bus_rd(8'h00, d);            chk("R5 read awake", d, 1);
    bus_wr(8'h00, 32'h0);        chk("R4 sticky zero", 32'(periph_active), 1);
    bus_wr(8'h00, 32'hFFFFFFFF); chk("R4 sticky ones", 32'(periph_active), 1);
    chk("R6 closed before pwd", 32'(access_en), 0);
  endtask

  task automatic t_open();
    logic [31:0] s, d;
    stb_probe(8'h0C, s);         chk("R10 strobe locked", s, 0);
    bus_rd(8'h0C, d);            chk("R11 locked read", d, 0);
    bus_wr(8'h04, 32'hFFFFA965); chk("R6 open upper ignored", 32'(access_en), 1);
    bus_rd(8'h04, d);            chk("R7 flag", d, 32'h0001_0000);
    stb_probe(8'h08, s);         chk("R10 first reg", s, 32'h1);
    stb_probe(8'h1C, s);         chk("R10 reg5", s, 32'h20);
    stb_probe(8'h54, s);         chk("R10 last reg", s, 32'h80000);
    stb_probe(8'h58, s);         chk("R10 past end", s, 0);
    stb_probe(8'h09, s);         chk("R10 unaligned", s, 0);
    bus_rd(8'h10, d);            chk("R11 open read", d, RDV);
    bus_rd(8'h80, d);            chk("R11 unmapped", d, 0);
  endtask

  task automatic t_bad();
    logic [31:0] s, d;
    bus_wr(8'h04, 32'h0000A964); chk("R8 bad pwd", 32'(access_en), 0);
    bus_rd(8'h04, d);            chk("R7 flag cleared", d, 0);
    bus_rd(8'h10, d);            chk("R11 read after bad", d, 0);
    stb_probe(8'h08, s);         chk("R10 strobe after bad", s, 0);
    chk("R4 still active", 32'(periph_active), 1);
  endtask

  task automatic t_window();
    bus_wr(8'h04, 32'hA965);
    repeat (WIN - 1) @(negedge clk);
    chk("R9 last open cycle", 32'(access_en), 1);
    @(negedge clk);
    chk("R9 expired", 32'(access_en), 0);
    bus_wr(8'h04, 32'hA965);
    repeat (10) @(negedge clk);
    bus_wr(8'h04, 32'hA965);
    repeat (WIN - 1) @(negedge clk);
    chk("R9 restarted window", 32'(access_en), 1);
    @(negedge clk);
    chk("R9 restarted expiry", 32'(access_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_asleep();
    t_wake();
    t_open();
    t_bad();
    t_window();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule